// File: doc/BRIEF.md
# Host Command Vector Register

This block is the register through which an external host processor asks the DSP core to run one of 64 preprogrammed exception routines. The host writes one byte. Bits 5:0 of that byte choose the routine and bit 7 is a "command pending" flag. When the host sets the flag, the block raises a request to the core's exception logic. The request carries the stored vector and the matching exception address, which is the vector times two.

The pending flag stays set until the core acknowledges that it accepted the command. It then clears by itself, so the host can poll the register to see when the command has been taken. While a command is pending, the block ignores every host write, so the vector cannot be corrupted under the core. The host can read the register back at any time. Only the host side can reach the register. The core sees nothing but the request outputs and drives only the acknowledge.

Top module: `host_cmd_vector`

## Requirements
- R1: After reset the readback value is 0x12: pending flag 0, bit 6 is 0, vector 0x12. The request output is low.
- R2: A host write with bit 7 = 1 while no command is pending stores bits 5:0 as the vector. The request output and the vector output show the new command from the next clock edge.
- R3: The readback byte is {pending flag, 1'b0, vector}. Bit 7 is the pending flag, bit 6 always reads 0 whatever was written, and bits 5:0 are the stored vector. Readback depends only on stored state.
- R4: The request stays high until the acknowledge input is sampled high, and it is low from the next edge on. An acknowledge while nothing is pending has no effect.
- R5: While a command is pending, a host write changes neither the vector nor the pending flag. This also holds in the cycle the acknowledge arrives, and it holds for a write with bit 7 = 0.
- R6: A host write with bit 7 = 0 while nothing is pending updates the vector and raises no request.
- R7: The exception address output equals the vector times two, 7 bits wide, from 0 for vector 0 up to 126 for vector 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe for this register |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host readback byte |
| coreAck | input | 1 | Core accepted the pending command |
| cmdPending | output | 1 | Command request to the core |
| cmdVector | output | 6 | Vector of the pending command |
| cmdAddr | output | 7 | Exception address, vector times two |

## Verification
The directed sequences cover a vector-only load, a command with bit 6 set, and an attempt to cancel or overwrite a pending command. They also cover a pending request held several cycles before the acknowledge, an acknowledge with nothing pending, and an acknowledge in the same cycle as a host write. Together these separate a correct lockout from one that blocks only the vector field, or one that lets the host cancel a command. The vector extremes 0 and 63 show whether the doubling of the address is right at both ends. A long stretch of random writes and acknowledges, compared every cycle against a behavioural model, catches ordering faults that the directed cases miss.

// File: rtl/hcv_pkg.sv
package hcv_pkg;
  typedef struct packed {
    logic loadVec;   // capture host vector
    logic setPend;   // raise request
    logic clrPend;   // drop request after core acknowledge
  } hcvStrobes_t;

  typedef enum logic [0:0] {
    HCV_IDLE = 1'b0,
    HCV_PEND = 1'b1
  } hcvState_t;
endpackage

// File: rtl/hcv_ctrl.sv
module hcv_ctrl
  import hcv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic        hostWrHc,
  input  logic        coreAck,
  output hcvStrobes_t strobes,
  output logic        pending
);
  hcvState_t state, stateNext;

  always_comb begin
    strobes = '0;
    stateNext = state;
    unique case (state)
      HCV_IDLE: begin
        // Host owns the register while nothing is pending.
        strobes.loadVec = hostWrEn;
        strobes.setPend = hostWrEn && hostWrHc;
        if (strobes.setPend) stateNext = HCV_PEND;
      end
      HCV_PEND: begin
        // Core owns it; host writes are locked out.
        strobes.clrPend = coreAck;
        if (strobes.clrPend) stateNext = HCV_IDLE;
      end
      default: stateNext = HCV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= HCV_IDLE;
    else       state <= stateNext;
  end

  assign pending = (state == HCV_PEND);
endmodule

// File: rtl/hcv_datapath.sv
module hcv_datapath
  import hcv_pkg::*;
#(
  parameter int VEC_W = 6,
  parameter logic [VEC_W-1:0] RESET_VEC = 6'h12,
  localparam int DATA_W = VEC_W + 2,
  localparam int ADDR_W = VEC_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hcvStrobes_t       strobes,
  input  logic              pending,
  input  logic [VEC_W-1:0]  hostWrVec,
  output logic [DATA_W-1:0] hostRdData,
  output logic [VEC_W-1:0]  cmdVector,
  output logic [ADDR_W-1:0] cmdAddr
);
  logic [VEC_W-1:0] vecReg;
  logic             unusedClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                vecReg <= RESET_VEC;
    else if (strobes.loadVec) vecReg <= hostWrVec;
  end

  assign unusedClr  = strobes.clrPend ^ strobes.setPend;
  assign hostRdData = {pending, 1'b0, vecReg};
  assign cmdVector  = vecReg;
  assign cmdAddr    = {vecReg, 1'b0};
endmodule

// File: rtl/host_cmd_vector.sv
module host_cmd_vector
  import hcv_pkg::*;
#(
  parameter int VEC_W = 6,
  parameter logic [VEC_W-1:0] RESET_VEC = 6'h12,
  localparam int DATA_W = VEC_W + 2,
  localparam int ADDR_W = VEC_W + 1,
  localparam int HC_POS = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              coreAck,
  output logic              cmdPending,
  output logic [VEC_W-1:0]  cmdVector,
  output logic [ADDR_W-1:0] cmdAddr
);
  hcvStrobes_t strobes;
  logic        unusedPad;

  // Bit 6 is a spacer: written data there is dropped.
  assign unusedPad = hostWrData[VEC_W];

  hcv_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .hostWrHc (hostWrData[HC_POS]),
    .coreAck  (coreAck),
    .strobes  (strobes),
    .pending  (cmdPending)
  );

  hcv_datapath #(.VEC_W(VEC_W), .RESET_VEC(RESET_VEC)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pending    (cmdPending),
    .hostWrVec  (hostWrData[VEC_W-1:0]),
    .hostRdData (hostRdData),
    .cmdVector  (cmdVector),
    .cmdAddr    (cmdAddr)
  );
endmodule

// File: rtl/host_cmd_vector_chk.sv
module host_cmd_vector_chk #(
  parameter int VEC_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWrEn,
  input logic [VEC_W+1:0] hostWrData,
  input logic [VEC_W+1:0] hostRdData,
  input logic             coreAck,
  input logic             cmdPending,
  input logic [VEC_W-1:0] cmdVector
);
  AST_SET_ON_HC: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdPending && hostWrEn && hostWrData[VEC_W+1]) |=>
      (cmdPending && cmdVector == $past(hostWrData[VEC_W-1:0]))); // R2
  AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdPending && !(hostWrEn && hostWrData[VEC_W+1])) |=> !cmdPending); // R6
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    hostRdData[VEC_W] == 1'b0); // R3
  AST_HOLD_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPending && !coreAck) |=> cmdPending); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPending && coreAck) |=> !cmdPending); // R4
  AST_VEC_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    cmdPending |=> $stable(cmdVector)); // R5
endmodule

bind host_cmd_vector host_cmd_vector_chk #(.VEC_W(VEC_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostWrData (hostWrData),
  .hostRdData (hostRdData),
  .coreAck    (coreAck),
  .cmdPending (cmdPending),
  .cmdVector  (cmdVector)
);

// File: tb/test_host_cmd_vector.sv
`timescale 1ns/1ps
module test_host_cmd_vector;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic [7:0] hostRdData;
  logic       coreAck = 1'b0;
  logic       cmdPending;
  logic [5:0] cmdVector;
  logic [6:0] cmdAddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference model
  bit mPend;
  int mVec;

  always #10 clk = ~clk;   // 50 MHz

  host_cmd_vector i_host_cmd_vector (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .coreAck(coreAck), .cmdPending(cmdPending),
    .cmdVector(cmdVector), .cmdAddr(cmdAddr)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPend <= 1'b0;
      mVec  <= 18;
    end else if (mPend) begin
      if (coreAck) mPend <= 1'b0;
    end else if (hostWrEn) begin
      mVec  <= int'(hostWrData[5:0]);
      mPend <= hostWrData[7];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(cmdPending == mPend, "R4 pending", int'(cmdPending), int'(mPend));
      check(int'(cmdVector) == mVec, "R5 vector", int'(cmdVector), mVec);
      check(int'(hostRdData) == (int'(mPend) * 128 + mVec), "R3 readback",
            int'(hostRdData), int'(mPend) * 128 + mVec);
      check(int'(cmdAddr) == mVec * 2, "R7 address", int'(cmdAddr), mVec * 2);
    end
  end

  task automatic step(input bit we, input logic [7:0] d, input bit ack);
    @(negedge clk);
    hostWrEn = we;
    hostWrData = d;
    coreAck = ack;
    @(posedge clk);
    #1;
    hostWrEn = 1'b0;
    coreAck = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(hostRdData == 8'h12, "R1 reset readback", int'(hostRdData), 'h12);
    check(cmdPending == 1'b0, "R1 reset pending", int'(cmdPending), 0);

    step(1'b1, 8'h05, 1'b0);           // R6 vector only
    @(negedge clk);
    check(!cmdPending && cmdVector == 6'h05, "R6 vector load",
          int'(hostRdData), 'h05);

    step(1'b1, 8'hC3, 1'b0);           // R2 with bit 6 set
    @(negedge clk);
    check(hostRdData == 8'h83, "R2 command set, R3 bit6 zero", int'(hostRdData), 'h83);

    step(1'b1, 8'h3F, 1'b0);           // R5 overwrite blocked
    step(1'b1, 8'h00, 1'b0);           // R5 cancel blocked
    idle(3);                           // R4 held
    @(negedge clk);
    check(hostRdData == 8'h83, "R5 lockout", int'(hostRdData), 'h83);

    step(1'b0, 8'h00, 1'b1);           // R4 ack
    @(negedge clk);
    check(!cmdPending && cmdAddr == 7'd6, "R4 ack clear", int'(hostRdData), 'h03);

    step(1'b0, 8'h00, 1'b1);           // R4 stray ack
    @(negedge clk);
    check(hostRdData == 8'h03, "R4 idle ack", int'(hostRdData), 'h03);

    step(1'b1, 8'hBF, 1'b0);           // R7 top vector
    @(negedge clk);
    check(cmdAddr == 7'd126, "R7 top address", int'(cmdAddr), 126);

    step(1'b1, 8'h81, 1'b1);           // R5 write with ack same cycle
    @(negedge clk);
    check(hostRdData == 8'h3F, "R5 ack-cycle write ignored", int'(hostRdData), 'h3F);

    step(1'b1, 8'h80, 1'b0);           // R7 vector zero
    @(negedge clk);
    check(cmdPending && cmdAddr == 7'd0, "R7 zero address", int'(cmdAddr), 0);
    step(1'b0, 8'h00, 1'b1);

    for (int i = 0; i < 2000; i++)
      step(($urandom % 2) == 1, 8'($urandom), ($urandom % 3) == 0);

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule